// File: doc/BRIEF.md
# Compressed Iota Vector Generator

This block builds a packed index vector from a 64-bit element mask. After a start pulse it visits the element positions 0 through length-1, one per clock. It keeps a running 32-bit offset that begins at zero and grows by a programmable stride at every position. Each position whose mask bit matches the select polarity sends the current offset to the next free slot of a destination vector register, so the written slots are always consecutive from slot 0.

When the sweep ends, the block pulses `done_o` for one cycle and presents the number of slots written on `count_o`. That value stays on `count_o` until the next operation completes, so a following vector operation can use it as its element count. Mask, polarity, stride and length are captured in the start cycle. The inputs may change freely afterwards.

Top module: `cmp_iota_gen`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `wr_en_o` are low and `count_o` is zero.
- R2: A start accepted at a clock edge makes `busy_o` high from the next cycle for exactly L cycles, with position k handled in the k-th of them (k from 0). L is the clamped length.
- R3: Position k is selected when mask bit k equals `sel_pol_i`, as captured at start. `wr_en_o` is high in that position's cycle exactly when it is selected.
- R4: A selected position k writes `wr_data_o` = k × stride modulo 2^32. The offset advances at every position, whether it is selected or not.
- R5: `wr_idx_o` is 0 for the first write of an operation and rises by one with each further write.
- R6: `done_o` is high for exactly one cycle, in the cycle after the last position. In that cycle `count_o` equals the number of writes made, and it keeps that value afterwards.
- R7: A length of zero makes no write and raises `done_o` in the cycle after the start, with `count_o` equal to 0.
- R8: A length above NUM_ELEM (64) is handled as NUM_ELEM.
- R9: A start pulse while `busy_o` or `done_o` is high is ignored. The running operation, its outputs and its count are unchanged.
- R10: During an operation, `count_o` keeps the value of the previous completed operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| sel_pol_i | input | 1 | Mask polarity that selects a position |
| stride_i | input | 32 | Offset increment per position |
| vlen_i | input | 7 | Number of positions to visit |
| mask_i | input | 64 | Element mask, bit k for position k |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wr_en_o | output | 1 | Destination slot write enable |
| wr_idx_o | output | 6 | Destination slot index |
| wr_data_o | output | 32 | Offset written to the slot |
| count_o | output | 7 | Slots written by the last completed operation |

## Verification
The write port for position k is due k+1 cycles after the edge that samples the start. The completion pulse and its count are due L+1 cycles after that edge, or one cycle after it when the length is zero. The bench drives the start on a falling edge and then steps one falling edge per position. At each step it compares the port values with a model that counts positions, slots and offsets independently of the RTL. Every sample therefore falls midway between the edge that updates the outputs and the following edge.

// File: rtl/iota_pkg.sv
package iota_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } iota_state_e;

endpackage

// File: rtl/iota_ctrl.sv
module iota_ctrl
    import iota_pkg::*;
#(
    parameter int NUM_ELEM = 64,
    parameter int LEN_W    = 7,
    parameter int IDX_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] vlen_i,
    output logic             accept_o,
    output logic             step_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             done_o
);

    typedef struct packed {
        iota_state_e      st;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
    } ctrl_t;

    ctrl_t q, d;
    logic [LEN_W-1:0] eff_len;
    logic [LEN_W-1:0] last_full;

    always_comb begin
        d         = q;
        accept_o  = 1'b0;
        eff_len   = (vlen_i > LEN_W'(NUM_ELEM)) ? LEN_W'(NUM_ELEM) : vlen_i;
        last_full = eff_len - LEN_W'(1);
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    accept_o = 1'b1;
                    d.idx    = '0;
                    d.last   = last_full[IDX_W-1:0];
                    d.st     = (eff_len == '0) ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                if (q.idx == q.last) begin
                    d.st = ST_FIN;
                end else begin
                    d.idx = q.idx + IDX_W'(1);
                end
            end
            ST_FIN:  d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.idx  <= '0;
            q.last <= '0;
        end else begin
            q <= d;
        end
    end

    assign step_o = (q.st == ST_RUN);
    assign done_o = (q.st == ST_FIN);
    assign idx_o  = q.idx;

endmodule

// File: rtl/iota_lane.sv
module iota_lane #(
    parameter int NUM_ELEM = 64,
    parameter int DATA_W   = 32,
    parameter int LEN_W    = 7,
    parameter int IDX_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept_i,
    input  logic                step_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [NUM_ELEM-1:0] mask_i,
    input  logic                sel_pol_i,
    input  logic [DATA_W-1:0]   stride_i,
    output logic                wr_en_o,
    output logic [IDX_W-1:0]    wr_idx_o,
    output logic [DATA_W-1:0]   wr_data_o,
    output logic [LEN_W-1:0]    packed_o
);

    typedef struct packed {
        logic [NUM_ELEM-1:0] mask;
        logic                pol;
        logic [DATA_W-1:0]   stride;
        logic [DATA_W-1:0]   offset;
        logic [LEN_W-1:0]    slot;
    } lane_t;

    lane_t q, d;
    logic  hit;

    always_comb begin
        d   = q;
        hit = step_i && (q.mask[idx_i] == q.pol);
        if (accept_i) begin
            d.mask   = mask_i;
            d.pol    = sel_pol_i;
            d.stride = stride_i;
            d.offset = '0;
            d.slot   = '0;
        end else if (step_i) begin
            d.offset = q.offset + q.stride;
            if (hit) begin
                d.slot = q.slot + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wr_en_o   = hit;
    assign wr_idx_o  = q.slot[IDX_W-1:0];
    assign wr_data_o = q.offset;
    assign packed_o  = q.slot;

endmodule

// File: rtl/cmp_iota_gen.sv
module cmp_iota_gen #(
    parameter int NUM_ELEM = 64,
    parameter int DATA_W   = 32,
    parameter int LEN_W    = $clog2(NUM_ELEM + 1),
    parameter int IDX_W    = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                sel_pol_i,
    input  logic [DATA_W-1:0]   stride_i,
    input  logic [LEN_W-1:0]    vlen_i,
    input  logic [NUM_ELEM-1:0] mask_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                wr_en_o,
    output logic [IDX_W-1:0]    wr_idx_o,
    output logic [DATA_W-1:0]   wr_data_o,
    output logic [LEN_W-1:0]    count_o
);

    typedef struct packed {
        logic [LEN_W-1:0] count;
    } top_t;

    logic             accept;
    logic             step;
    logic [IDX_W-1:0] idx;
    logic             fin;
    logic [LEN_W-1:0] packed_cnt;
    top_t             q, d;

    iota_ctrl #(
        .NUM_ELEM (NUM_ELEM),
        .LEN_W    (LEN_W),
        .IDX_W    (IDX_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .vlen_i   (vlen_i),
        .accept_o (accept),
        .step_o   (step),
        .idx_o    (idx),
        .done_o   (fin)
    );

    iota_lane #(
        .NUM_ELEM (NUM_ELEM),
        .DATA_W   (DATA_W),
        .LEN_W    (LEN_W),
        .IDX_W    (IDX_W)
    ) lane_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .step_i    (step),
        .idx_i     (idx),
        .mask_i    (mask_i),
        .sel_pol_i (sel_pol_i),
        .stride_i  (stride_i),
        .wr_en_o   (wr_en_o),
        .wr_idx_o  (wr_idx_o),
        .wr_data_o (wr_data_o),
        .packed_o  (packed_cnt)
    );

    always_comb begin
        d = q;
        if (fin) begin
            d.count = packed_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o  = step;
    assign done_o  = fin;
    assign count_o = fin ? packed_cnt : q.count;

endmodule

// File: rtl/cmp_iota_gen_chk.sv
module cmp_iota_gen_chk #(
    parameter int NUM_ELEM = 64,
    parameter int DATA_W   = 32,
    parameter int LEN_W    = 7,
    parameter int IDX_W    = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                sel_pol_i,
    input logic [DATA_W-1:0]   stride_i,
    input logic [LEN_W-1:0]    vlen_i,
    input logic [NUM_ELEM-1:0] mask_i,
    input logic                busy_o,
    input logic                done_o,
    input logic                wr_en_o,
    input logic [IDX_W-1:0]    wr_idx_o,
    input logic [DATA_W-1:0]   wr_data_o,
    input logic [LEN_W-1:0]    count_o
);

    logic [LEN_W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (done_o) begin
            seen_q <= '0;
        end else if (wr_en_o) begin
            seen_q <= seen_q + LEN_W'(1);
        end
    end

    p_write_in_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> busy_o);

    p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_slot_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && busy_o) |=> (wr_idx_o == IDX_W'($past(wr_idx_o) + IDX_W'(1))));

    p_count_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (count_o == seen_q));

    p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> $stable(count_o));

endmodule

bind cmp_iota_gen cmp_iota_gen_chk #(
    .NUM_ELEM (NUM_ELEM),
    .DATA_W   (DATA_W),
    .LEN_W    (LEN_W),
    .IDX_W    (IDX_W)
) chk_i (.*);

// File: tb/cmp_iota_gen_tb_top.sv
module cmp_iota_gen_tb_top;

    localparam int NE = 64;
    localparam int DW = 32;
    localparam int LW = 7;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          sel_pol_i = 1'b1;
    logic [DW-1:0] stride_i = '0;
    logic [LW-1:0] vlen_i = '0;
    logic [NE-1:0] mask_i = '0;
    logic          busy_o, done_o, wr_en_o;
    logic [IW-1:0] wr_idx_o;
    logic [DW-1:0] wr_data_o;
    logic [LW-1:0] count_o;

    int errs = 0;
    int checks = 0;
    int prev_count = 0;
    logic [63:0] rng = 64'h1234_5678_9abc_def1;

    always #4 clk = ~clk;

    cmp_iota_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_pol_i(sel_pol_i),
        .stride_i(stride_i), .vlen_i(vlen_i), .mask_i(mask_i),
        .busy_o(busy_o), .done_o(done_o), .wr_en_o(wr_en_o),
        .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .count_o(count_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] next_rng(input logic [63:0] s);
        logic [63:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic run_op(input int vl, input logic [63:0] m, input bit pol,
                          input logic [31:0] stride, input bit poke);
        int eff;
        int slot;
        logic [31:0] off;
        bit sel;
        eff  = (vl > NE) ? NE : vl;
        slot = 0;
        off  = '0;
        @(negedge clk);
        start_i = 1'b1; vlen_i = LW'(vl); mask_i = m; sel_pol_i = pol; stride_i = stride;
        @(negedge clk);
        start_i = 1'b0; mask_i = ~m; sel_pol_i = ~pol; stride_i = stride + 32'd5;
        vlen_i = LW'(3);
        for (int k = 0; k < eff; k++) begin
            sel = (m[k] == pol);
            chk(busy_o == 1'b1, "R2", "busy during sweep", busy_o, 1);
            chk(wr_en_o == sel, "R3", "write enable", wr_en_o, sel);
            chk(count_o == LW'(prev_count), "R10", "count held", count_o, prev_count);
            if (sel) begin
                chk(wr_idx_o == IW'(slot), "R5", "slot index", wr_idx_o, slot);
                chk(wr_data_o == off, "R4", "offset", wr_data_o, off);
                slot++;
            end
            off = off + stride;
            start_i = (poke && k == 1);
            @(negedge clk);
            start_i = 1'b0;
        end
        chk(done_o == 1'b1, (vl == 0) ? "R7" : "R6", "done pulse", done_o, 1);
        chk(busy_o == 1'b0, "R2", "busy after sweep", busy_o, 0);
        chk(wr_en_o == 1'b0, "R3", "no write at done", wr_en_o, 0);
        chk(count_o == LW'(slot), (vl > NE) ? "R8" : "R6", "final count", count_o, slot);
        start_i = poke;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0, "R6", "done single cycle", done_o, 0);
        chk(busy_o == 1'b0, "R9", "start at done ignored", busy_o, 0);
        chk(count_o == LW'(slot), "R6", "count kept", count_o, slot);
        prev_count = slot;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int vls[12] = '{0, 1, 2, 3, 7, 31, 32, 33, 63, 64, 65, 127};
        logic [63:0] m;
        logic [31:0] st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1", "reset busy", busy_o, 0);
        chk(done_o == 1'b0, "R1", "reset done", done_o, 0);
        chk(wr_en_o == 1'b0, "R1", "reset write", wr_en_o, 0);
        chk(count_o == '0, "R1", "reset count", count_o, 0);
        foreach (vls[v]) begin
            for (int p = 0; p < 5; p++) begin
                for (int pol = 0; pol < 2; pol++) begin
                    rng = next_rng(rng);
                    case (p)
                        0: begin m = '1; st = 32'd4; end
                        1: begin m = '0; st = 32'hFFFF_FFFF; end
                        2: begin m = 64'hAAAA_AAAA_5555_5555; st = 32'h8000_0000; end
                        3: begin m = rng; st = 32'd12; end
                        default: begin m = next_rng(rng ^ 64'h77); st = rng[31:0]; end
                    endcase
                    run_op(vls[v], m, pol[0], st, (p == 3));
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule